// File: doc/BRIEF.md
# Configuration Window Address Decoder

This block holds one 64-bit base register for a memory-mapped PCI Express configuration window. It checks every 39-bit memory address against that window. Software writes the register through a plain write port and reads it back on a read-data output. The register holds an enable bit, a two-bit size selector and the base address bits 38:28.

When an address falls inside the enabled window, the block raises a hit flag. It also splits the address into a bus number, a device number, a function number and a byte offset inside the 4 KB region of that function. The window can be 256 MB, 128 MB or 64 MB. Each size halving removes one bus-number bit and adds one address bit that must be zero. An address that matches the 256 MB-aligned base but lies past the end of a smaller window is flagged as out of range. A lock input freezes the register against writes.

The decode outputs are combinational from the current address and the stored register. A register write affects decoding from the following clock edge.

Top module: `cfgwin_decoder`

## Requirements
- R1: After a synchronous reset the read-back value is all zero. No address produces a hit or an out-of-range flag until a write sets the enable bit (bit 0).
- R2: Register bits 63:39 and 27:3 always read as zero, whatever value was written to them.
- R3: When the register is unlocked, a write stores data bits 38:28 (base), 2:1 (size) and 0 (enable). The stored value appears on the read-back output from the next clock edge.
- R4: While the lock input is high, a write changes no register bit. Decoding keeps using the old contents.
- R5: With the enable bit clear, the hit flag and the out-of-range flag stay low for every address.
- R6: Size code 00 (256 MB, 256 buses): an enabled window hits when address bits 38:28 equal the base. The bus number is address bits 27:20.
- R7: Size code 01 (128 MB, 128 buses): a hit also needs address bit 27 to be zero. The bus number is address bits 26:20, zero-extended to 8 bits.
- R8: Size code 10 (64 MB, 64 buses): a hit also needs address bits 27:26 to be zero. The bus number is address bits 25:20, zero-extended to 8 bits.
- R9: Size code 11 is reserved. It raises the size-error flag whether or not the enable bit is set, and no address hits or is flagged out of range.
- R10: On a hit, the device number is address bits 19:15, the function is bits 14:12 and the offset is bits 11:0. When there is no hit, bus, device, function and offset are all zero.
- R11: With an enabled, valid size, the out-of-range flag is high when address bits 38:28 equal the base but an address bit that must be zero for that size is set. It is never high together with the hit flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 64 | Register write data |
| cfg_lock | input | 1 | Freezes the register when high |
| cfg_rd_data | output | 64 | Current register contents |
| mem_addr | input | 39 | Memory address to decode |
| win_hit | output | 1 | Address lies in the enabled window |
| win_oor | output | 1 | Address passes the base compare but is past the window end |
| win_len_err | output | 1 | Reserved size code programmed |
| cfg_bus | output | 8 | Bus number of a hit |
| cfg_dev | output | 5 | Device number of a hit |
| cfg_fn | output | 3 | Function number of a hit |
| cfg_off | output | 12 | Byte offset in the 4 KB function region |

## Verification
A register write and an address decode can fall in the same cycle. In that cycle the decode must still reflect the old base, size and enable, and the new contents must govern only from the following edge. The bench provokes this by writing a new base or size while presenting addresses inside the new window. It also does this with the lock input high, where the old contents must stay in force. A behavioural model updates its copy of the register on the clock edge and recomputes every output. The design is compared against that model after each edge.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam int CW_ADDR_W  = 39;
  localparam int CW_REG_W   = 64;
  localparam int CW_BASE_LO = 28;
  localparam int CW_BUS_LO  = 20;
  localparam int CW_DEV_LO  = 15;
  localparam int CW_FN_LO   = 12;
  localparam int CW_NUM_LEN = 3;
  localparam int CW_LEN_W   = 2;
  localparam int CW_EN_BIT  = 0;
  localparam int CW_LEN_LO  = 1;

  typedef enum logic [CW_LEN_W-1:0] {
    SZ_FULL    = 2'b00,
    SZ_HALF    = 2'b01,
    SZ_QUARTER = 2'b10,
    SZ_RSVD    = 2'b11
  } win_size_e;
endpackage

// File: rtl/cfgwin_regfile.sv
module cfgwin_regfile
  import cfgwin_pkg::*;
#(
  parameter int ADDR_W  = CW_ADDR_W,
  parameter int BASE_LO = CW_BASE_LO,
  parameter int REG_W   = CW_REG_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [REG_W-1:0]          wr_data,
  input  logic                      lock,
  output logic [ADDR_W-1:BASE_LO]   base_o,
  output win_size_e                 size_o,
  output logic                      en_o,
  output logic [REG_W-1:0]          rd_data
);
  localparam int BASE_W = ADDR_W - BASE_LO;

  logic [BASE_W-1:0]   base_q;
  logic [CW_LEN_W-1:0] size_q;
  logic                en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      size_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_en && !lock) begin
      base_q <= wr_data[ADDR_W-1:BASE_LO];
      size_q <= wr_data[CW_LEN_LO +: CW_LEN_W];
      en_q   <= wr_data[CW_EN_BIT];
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[ADDR_W-1:BASE_LO]       = base_q;
    rd_data[CW_LEN_LO +: CW_LEN_W]  = size_q;
    rd_data[CW_EN_BIT]              = en_q;
  end

  assign base_o = base_q;
  assign size_o = win_size_e'(size_q);
  assign en_o   = en_q;

  assert_lock_hold_R4: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(rd_data));

  assert_write_take_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !lock) |=>
      (rd_data[ADDR_W-1:BASE_LO] == $past(wr_data[ADDR_W-1:BASE_LO])) &&
      (rd_data[CW_LEN_LO +: CW_LEN_W] == $past(wr_data[CW_LEN_LO +: CW_LEN_W])) &&
      (rd_data[CW_EN_BIT] == $past(wr_data[CW_EN_BIT])));
endmodule

// File: rtl/cfgwin_matcher.sv
module cfgwin_matcher
  import cfgwin_pkg::*;
#(
  parameter int ADDR_W  = CW_ADDR_W,
  parameter int BASE_LO = CW_BASE_LO,
  parameter int NUM_LEN = CW_NUM_LEN
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [ADDR_W-1:BASE_LO]  base,
  input  win_size_e                size,
  input  logic                     en,
  output logic                     hit,
  output logic                     oor,
  output logic                     size_err
);
  localparam int SUB_W = (NUM_LEN > 1) ? NUM_LEN - 1 : 1;

  logic                upper_eq;
  logic [NUM_LEN-1:0]  extra_nz;
  logic                sel_nz;
  logic                size_ok;

  assign upper_eq = (addr[ADDR_W-1:BASE_LO] == base);

  // One tail check per window size: size k needs its top k sub-base bits zero.
  for (genvar k = 0; k < NUM_LEN; k++) begin : g_tail
    localparam logic [SUB_W-1:0] TAIL_MASK = ~({SUB_W{1'b1}} >> k);
    assign extra_nz[k] = |(addr[BASE_LO-1 -: SUB_W] & TAIL_MASK);
  end

  always_comb begin
    size_ok = 1'b0;
    sel_nz  = 1'b0;
    for (int k = 0; k < NUM_LEN; k++) begin
      if (size == win_size_e'(k)) begin
        size_ok = 1'b1;
        sel_nz  = extra_nz[k];
      end
    end
  end

  assign size_err = !size_ok;
  assign hit      = en && size_ok && upper_eq && !sel_nz;
  assign oor      = en && size_ok && upper_eq && sel_nz;
endmodule

// File: rtl/cfgwin_split.sv
module cfgwin_split
  import cfgwin_pkg::*;
#(
  parameter int ADDR_W  = CW_ADDR_W,
  parameter int BASE_LO = CW_BASE_LO,
  parameter int BUS_LO  = CW_BUS_LO,
  parameter int DEV_LO  = CW_DEV_LO,
  parameter int FN_LO   = CW_FN_LO,
  parameter int NUM_LEN = CW_NUM_LEN
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      hit,
  input  win_size_e                 size,
  output logic [BASE_LO-BUS_LO-1:0] bus,
  output logic [BUS_LO-DEV_LO-1:0]  dev,
  output logic [DEV_LO-FN_LO-1:0]   fn,
  output logic [FN_LO-1:0]          off
);
  localparam int BUS_W = BASE_LO - BUS_LO;

  logic [BUS_W-1:0] bus_opt [NUM_LEN];
  logic [BUS_W-1:0] bus_sel;

  // Each halving of the window drops the top bus bit.
  for (genvar k = 0; k < NUM_LEN; k++) begin : g_bus
    localparam logic [BUS_W-1:0] BUS_MASK = {BUS_W{1'b1}} >> k;
    assign bus_opt[k] = addr[BUS_LO +: BUS_W] & BUS_MASK;
  end

  always_comb begin
    bus_sel = '0;
    for (int k = 0; k < NUM_LEN; k++) begin
      if (size == win_size_e'(k)) bus_sel = bus_opt[k];
    end
  end

  assign bus = hit ? bus_sel : '0;
  assign dev = hit ? addr[DEV_LO +: (BUS_LO-DEV_LO)] : '0;
  assign fn  = hit ? addr[FN_LO +: (DEV_LO-FN_LO)] : '0;
  assign off = hit ? addr[FN_LO-1:0] : '0;
endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder
  import cfgwin_pkg::*;
#(
  parameter int ADDR_W  = CW_ADDR_W,
  parameter int REG_W   = CW_REG_W,
  parameter int BASE_LO = CW_BASE_LO,
  parameter int BUS_LO  = CW_BUS_LO,
  parameter int DEV_LO  = CW_DEV_LO,
  parameter int FN_LO   = CW_FN_LO,
  parameter int NUM_LEN = CW_NUM_LEN
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_wr_en,
  input  logic [REG_W-1:0]            cfg_wr_data,
  input  logic                        cfg_lock,
  output logic [REG_W-1:0]            cfg_rd_data,
  input  logic [ADDR_W-1:0]           mem_addr,
  output logic                        win_hit,
  output logic                        win_oor,
  output logic                        win_len_err,
  output logic [BASE_LO-BUS_LO-1:0]   cfg_bus,
  output logic [BUS_LO-DEV_LO-1:0]    cfg_dev,
  output logic [DEV_LO-FN_LO-1:0]     cfg_fn,
  output logic [FN_LO-1:0]            cfg_off
);
  localparam int BASE_W = ADDR_W - BASE_LO;

  logic [BASE_W-1:0] base_w;
  win_size_e         size_w;
  logic              en_w;

  cfgwin_regfile #(
    .ADDR_W (ADDR_W),
    .BASE_LO(BASE_LO),
    .REG_W  (REG_W)
  ) u_reg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_wr_en),
    .wr_data(cfg_wr_data),
    .lock   (cfg_lock),
    .base_o (base_w),
    .size_o (size_w),
    .en_o   (en_w),
    .rd_data(cfg_rd_data)
  );

  cfgwin_matcher #(
    .ADDR_W (ADDR_W),
    .BASE_LO(BASE_LO),
    .NUM_LEN(NUM_LEN)
  ) u_match (
    .addr    (mem_addr),
    .base    (base_w),
    .size    (size_w),
    .en      (en_w),
    .hit     (win_hit),
    .oor     (win_oor),
    .size_err(win_len_err)
  );

  cfgwin_split #(
    .ADDR_W (ADDR_W),
    .BASE_LO(BASE_LO),
    .BUS_LO (BUS_LO),
    .DEV_LO (DEV_LO),
    .FN_LO  (FN_LO),
    .NUM_LEN(NUM_LEN)
  ) u_split (
    .addr(mem_addr),
    .hit (win_hit),
    .size(size_w),
    .bus (cfg_bus),
    .dev (cfg_dev),
    .fn  (cfg_fn),
    .off (cfg_off)
  );

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd_data[REG_W-1:ADDR_W] == '0) &&
    (cfg_rd_data[BASE_LO-1:CW_LEN_LO+CW_LEN_W] == '0));

  assert_hit_needs_en_R5: assert property (@(posedge clk) disable iff (rst)
    (win_hit || win_oor) |-> cfg_rd_data[CW_EN_BIT]);

  assert_hit_base_R6: assert property (@(posedge clk) disable iff (rst)
    win_hit |-> (mem_addr[ADDR_W-1:BASE_LO] == cfg_rd_data[ADDR_W-1:BASE_LO]));

  assert_rsvd_size_R9: assert property (@(posedge clk) disable iff (rst)
    win_len_err |-> (!win_hit && !win_oor));

  assert_idle_fields_R10: assert property (@(posedge clk) disable iff (rst)
    !win_hit |-> (cfg_bus == '0 && cfg_dev == '0 && cfg_fn == '0 && cfg_off == '0));

  assert_oor_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(win_hit && win_oor));
endmodule

// File: tb/sim_cfgwin_decoder.sv
module sim_cfgwin_decoder;
  localparam logic [63:0] KEEP = 64'h0000_007F_F000_0007;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wen = 1'b0;
  logic [63:0] wdata = '0;
  logic        lk = 1'b0;
  logic [38:0] addr = '0;
  logic [63:0] rd;
  logic        hit, oor, lerr;
  logic [7:0]  bus;
  logic [4:0]  dev;
  logic [2:0]  fn;
  logic [11:0] off;

  int    checks = 0;
  int    errors = 0;
  bit    running = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";
  logic [63:0] m_reg = '0;

  always #2 clk = ~clk;

  cfgwin_decoder u0 (
    .clk(clk), .rst(rst), .cfg_wr_en(wen), .cfg_wr_data(wdata), .cfg_lock(lk),
    .cfg_rd_data(rd), .mem_addr(addr), .win_hit(hit), .win_oor(oor),
    .win_len_err(lerr), .cfg_bus(bus), .cfg_dev(dev), .cfg_fn(fn), .cfg_off(off)
  );

  // Reference register: updated on the clock edge like software expects.
  always @(posedge clk) begin
    if (rst) m_reg <= '0;
    else if (wen && !lk) m_reg <= wdata & KEEP;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running && !rst) begin
      int    sz;
      bit    en, up, tail, e_hit, e_oor, e_err;
      logic [7:0] e_bus;
      sz   = int'(m_reg[2:1]);
      en   = m_reg[0];
      up   = (addr[38:28] == m_reg[38:28]);
      tail = (sz == 1 && addr[27]) || (sz == 2 && addr[27:26] != 2'b00);
      e_err = (sz == 3);
      e_hit = en && !e_err && up && !tail;
      e_oor = en && !e_err && up && tail;
      e_bus = e_hit ? (addr[27:20] & (8'hFF >> sz)) : 8'h00;
      chk(rd === m_reg, "R3", "readback", rd, m_reg);
      chk((rd & ~KEEP) === 64'h0, "R2", "reserved bits", rd & ~KEEP, 64'h0);
      chk(hit === e_hit, cur_req, "hit", 64'(hit), 64'(e_hit));
      chk(oor === e_oor, "R11", "out-of-range", 64'(oor), 64'(e_oor));
      chk(lerr === e_err, "R9", "size error", 64'(lerr), 64'(e_err));
      chk(bus === e_bus, cur_req, "bus", 64'(bus), 64'(e_bus));
      chk(dev === (e_hit ? addr[19:15] : 5'd0), "R10", "device", 64'(dev),
          64'(e_hit ? addr[19:15] : 5'd0));
      chk(fn === (e_hit ? addr[14:12] : 3'd0), "R10", "function", 64'(fn),
          64'(e_hit ? addr[14:12] : 3'd0));
      chk(off === (e_hit ? addr[11:0] : 12'd0), "R10", "offset", 64'(off),
          64'(e_hit ? addr[11:0] : 12'd0));
    end
  end

  task automatic step(input bit w, input logic [63:0] d, input bit l, input logic [38:0] a);
    @(posedge clk);
    #1;
    wen = w; wdata = d; lk = l; addr = a;
  endtask

  function automatic logic [63:0] regval(input logic [10:0] b, input logic [1:0] s, input bit e);
    return {25'h0, b, 25'h0, s, e};
  endfunction

  function automatic logic [38:0] near(input logic [10:0] b);
    return {b, 28'($urandom)};
  endfunction

  task automatic sweep(input string req, input logic [10:0] b, input int n);
    cur_req = req;
    for (int i = 0; i < n; i++) begin
      if (i % 4 == 3) step(1'b0, '0, 1'b0, 39'($urandom) ^ {7'($urandom), 32'h0});
      else step(1'b0, '0, 1'b0, near(b));
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    running = 1'b1;
    // R1: reset contents, address 0 matches base 0 but window is off
    cur_req = "R1";
    chk(rd === 64'h0, "R1", "reset readback", rd, 64'h0);
    step(1'b0, '0, 1'b0, 39'h0);
    step(1'b0, '0, 1'b0, 39'h0_0012_3456);
    // R2/R9: all-ones write keeps only defined fields, size 11 reserved
    cur_req = "R9";
    step(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 39'h7F_F000_0000);
    sweep("R9", 11'h7FF, 12);
    // R5: enable clear
    step(1'b1, regval(11'h005, 2'b00, 1'b0), 1'b0, near(11'h005));
    sweep("R5", 11'h005, 12);
    // R6 / R7 / R8
    step(1'b1, regval(11'h005, 2'b00, 1'b1), 1'b0, near(11'h005));
    sweep("R6", 11'h005, 40);
    step(1'b1, regval(11'h3A1, 2'b01, 1'b1), 1'b0, near(11'h3A1));
    sweep("R7", 11'h3A1, 40);
    step(1'b1, regval(11'h0C4, 2'b10, 1'b1), 1'b0, near(11'h0C4));
    sweep("R8", 11'h0C4, 40);
    // R11: edge addresses around the end of a 64 MB window
    cur_req = "R11";
    step(1'b0, '0, 1'b0, {11'h0C4, 28'h3FF_FFFF});
    step(1'b0, '0, 1'b0, {11'h0C4, 28'h400_0000});
    step(1'b0, '0, 1'b0, {11'h0C4, 28'h800_0000});
    step(1'b0, '0, 1'b0, {11'h0C5, 28'h000_0000});
    // R10: field extraction at the full window extremes
    step(1'b1, regval(11'h7FF, 2'b00, 1'b1), 1'b0, 39'h7F_FFFF_FFFF);
    cur_req = "R10";
    step(1'b0, '0, 1'b0, 39'h7F_FFFF_FFFF);
    step(1'b0, '0, 1'b0, 39'h7F_F000_0000);
    step(1'b0, '0, 1'b0, {11'h7FF, 8'hA5, 5'h13, 3'h6, 12'hABC});
    // R4: writes while locked are dropped
    cur_req = "R4";
    for (int i = 0; i < 10; i++)
      step(1'b1, {32'($urandom), 32'($urandom)}, 1'b1, near(11'h7FF));
    step(1'b0, '0, 1'b0, near(11'h7FF));
    chk(rd === regval(11'h7FF, 2'b00, 1'b1), "R4", "locked readback", rd,
        regval(11'h7FF, 2'b00, 1'b1));
    // Same-cycle write and decode, unlocked and locked
    cur_req = "R3";
    for (int i = 0; i < 30; i++) begin
      logic [10:0] nb;
      nb = 11'($urandom);
      step(1'b1, regval(nb, 2'($urandom % 3), 1'b1), bit'($urandom % 2), near(nb));
      step(1'b0, '0, 1'b0, near(nb));
    end
    step(1'b0, '0, 1'b0, '0);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule